// File: doc/BRIEF.md
# Lane-Masked Synchronous Word Store with Write Forwarding

This block is the storage core of a synchronous burst memory. It holds words of 36 bits, split into four byte lanes of nine bits each (eight data bits and one parity bit). Each clock edge captures one request: an address from an external burst sequencer, write data, a chip select and a set of active-low write controls. The write controls decode into a lane mask. A global write forces all four lanes. Per-lane enables count only while a byte-write qualifier is asserted. With no lane selected, the cycle is a read.

A captured write is not committed to the array on the next edge. It first moves into a single-entry hold register, and the array write port takes it one edge later. A read captured in the cycle right after a write to the same address therefore takes the written lanes from the hold register and the other lanes from the array. Read data is never registered on the way out. It comes straight from the captured address through the forwarding merge. It is driven only while the asynchronous output enable is low and the current cycle is a read.

Two small state machines shape the behaviour. The request register holds the current cycle kind: IDLE (deselected), READ or WRITE. The hold register has two states, EMPTY and FULL, with four transitions: STAY (EMPTY to EMPTY when no write was captured), LOAD (EMPTY to FULL on a captured write), RELOAD (FULL to FULL, committing one write while taking the next) and DRAIN (FULL to EMPTY, committing the last write).

Top module: `sram_bw_core`

## Requirements
- R1: With `sel` high and `glob_we_n` low, all four lanes at `addr` take `wdata`, whatever `byte_we_n` and `lane_we_n` are.
- R2: With `sel` high, `glob_we_n` high and `byte_we_n` low, exactly the lanes k whose `lane_we_n[k]` is 0 take `wdata`, and the other lanes keep their contents.
- R3: With `glob_we_n` and `byte_we_n` both high, or with `byte_we_n` low and every `lane_we_n` bit high, the cycle is a read and no lane is modified.
- R4: Lane k covers data bits 8k to 8k+7 and parity bit 32+k of `wdata` and `q`, for k = 0 to 3.
- R5: With `sel` low at an edge, nothing is written, and `q_drv` is low for the following cycle.
- R6: A read captured at an edge drives the stored word at that address on `q` during the following cycle, with no output register. `q_drv` follows `oe_n` combinationally and is high only while `oe_n` is low in a read cycle.
- R7: A read captured at the edge right after a write to the same address returns the new data in the written lanes and the stored contents in the others.
- R8: A write is visible to every later read, whatever the address or the spacing of that read, and it leaves other addresses unchanged.
- R9: During and right after reset, `q_drv` is low and no write is pending.
- R10: Whenever `q_drv` is low, `q` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all requests are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sel | input | 1 | Chip select, active high |
| addr | input | ADDR_W (6) | Word address from the burst sequencer |
| wdata | input | 36 | Write data; lane k is bits 8k..8k+7 plus bit 32+k |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| byte_we_n | input | 1 | Qualifier for the per-lane enables, active low |
| glob_we_n | input | 1 | Global write, active low, forces all lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q | output | 36 | Flow-through read data, zero while not driven |
| q_drv | output | 1 | Output driver enable for the pad ring |

## Verification
Every captured request shows its result during the cycle after its capture edge. The merged word and `q_drv` are valid one time step after the rising edge. The bench drives inputs on the falling edge and samples one time step after the rising edge. A write's effect must appear at that sample for a read one cycle later. Its effect on the array proper lands two edges after capture, and reads spaced two or more cycles out check it there. The output-enable path has no clock in it, so the bench toggles `oe_n` between edges and samples half a time step later.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;

    // Kind of the request held in the capture register
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    // Occupancy of the single-entry posted-write hold register
    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/sram_bw_wdec.sv
module sram_bw_wdec
    import sram_bw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             byte_we_n,
    input  logic             glob_we_n,
    output cyc_kind_e        kind,
    output logic [LANES-1:0] mask
);

    logic [LANES-1:0] raw_mask;

    // Global write overrides; lane enables count only when qualified
    always_comb begin
        if (!glob_we_n) begin
            raw_mask = '1;
        end else if (!byte_we_n) begin
            raw_mask = ~lane_we_n;
        end else begin
            raw_mask = '0;
        end
    end

    always_comb begin
        if (!sel) begin
            kind = CYC_IDLE;
            mask = '0;
        end else if (|raw_mask) begin
            kind = CYC_WRITE;
            mask = raw_mask;
        end else begin
            kind = CYC_READ;
            mask = '0;
        end
    end

endmodule

// File: rtl/sram_bw_ctrl.sv
module sram_bw_ctrl
    import sram_bw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_kind_e         kind_in,
    input  logic [LANES-1:0]  mask_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] data_in,
    output cyc_kind_e         req_kind,
    output logic [LANES-1:0]  req_mask,
    output logic [ADDR_W-1:0] req_addr,
    output hold_state_e       hold_state,
    output logic [LANES-1:0]  hold_mask,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [WORD_W-1:0] hold_data,
    output logic              commit_en
);

    logic [WORD_W-1:0] req_data;
    hold_state_e       hold_next;
    logic              load_hold;

    // Request capture: kind and mask reset, payload free-running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_kind <= CYC_IDLE;
            req_mask <= '0;
        end else begin
            req_kind <= kind_in;
            req_mask <= mask_in;
        end
    end

    always_ff @(posedge clk) begin
        req_addr <= addr_in;
        req_data <= data_in;
    end

    assign load_hold = (req_kind == CYC_WRITE);

    // Hold register state: STAY, LOAD, RELOAD, DRAIN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_state <= HOLD_EMPTY;
        end else begin
            hold_state <= hold_next;
        end
    end

    always_comb begin
        hold_next = hold_state;
        unique case (hold_state)
            HOLD_EMPTY: hold_next = load_hold ? HOLD_FULL : HOLD_EMPTY;
            HOLD_FULL:  hold_next = load_hold ? HOLD_FULL : HOLD_EMPTY;
            default:    hold_next = HOLD_EMPTY;
        endcase
    end

    // Hold payload and commit strobe
    always_ff @(posedge clk) begin
        if (load_hold) begin
            hold_mask <= req_mask;
            hold_addr <= req_addr;
            hold_data <= req_data;
        end
    end

    assign commit_en = (hold_state == HOLD_FULL);

    // R7: a captured write is in the hold register one edge later
    assert_hold_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == CYC_WRITE) |=> (hold_state == HOLD_FULL
            && hold_addr == $past(req_addr) && hold_mask == $past(req_mask)));

    // R8: the hold register drains once no new write arrives
    assert_hold_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind != CYC_WRITE) |=> (hold_state == HOLD_EMPTY));

endmodule

// File: rtl/sram_bw_array.sv
module sram_bw_array #(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_DW = 8,
    localparam int WORD_W   = LANES * (LANE_DW + 1),
    localparam int PAR_BASE = LANES * LANE_DW,
    localparam int DEPTH    = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    // One storage column per lane, each with its own write strobe
    for (genvar k = 0; k < LANES; k++) begin : g_col
        logic [LANE_DW:0] col [DEPTH];
        logic [LANE_DW:0] col_rd;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[k]) begin
                col[wr_addr] <= {wr_data[PAR_BASE + k], wr_data[k*LANE_DW +: LANE_DW]};
            end
        end

        assign col_rd                          = col[rd_addr];
        assign rd_data[k*LANE_DW +: LANE_DW]  = col_rd[LANE_DW-1:0];
        assign rd_data[PAR_BASE + k]           = col_rd[LANE_DW];
    end

    // R3: the write port is never strobed with an empty lane mask
    assert_commit_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_mask != '0));

endmodule

// File: rtl/sram_bw_core.sv
module sram_bw_core
    import sram_bw_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_DW = 8,
    localparam int WORD_W   = LANES * (LANE_DW + 1),
    localparam int PAR_BASE = LANES * LANE_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              byte_we_n,
    input  logic              glob_we_n,
    input  logic              oe_n,
    output logic [WORD_W-1:0] q,
    output logic              q_drv
);

    cyc_kind_e         dec_kind;
    logic [LANES-1:0]  dec_mask;
    cyc_kind_e         req_kind;
    logic [LANES-1:0]  req_mask;
    logic [ADDR_W-1:0] req_addr;
    hold_state_e       hold_state;
    logic [LANES-1:0]  hold_mask;
    logic [ADDR_W-1:0] hold_addr;
    logic [WORD_W-1:0] hold_data;
    logic              commit_en;
    logic [WORD_W-1:0] arr_data;
    logic [WORD_W-1:0] fwd_data;
    logic              fwd_hit;

    sram_bw_wdec #(.LANES(LANES)) u_wdec (
        .sel       (sel),
        .lane_we_n (lane_we_n),
        .byte_we_n (byte_we_n),
        .glob_we_n (glob_we_n),
        .kind      (dec_kind),
        .mask      (dec_mask)
    );

    sram_bw_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_in    (dec_kind),
        .mask_in    (dec_mask),
        .addr_in    (addr),
        .data_in    (wdata),
        .req_kind   (req_kind),
        .req_mask   (req_mask),
        .req_addr   (req_addr),
        .hold_state (hold_state),
        .hold_mask  (hold_mask),
        .hold_addr  (hold_addr),
        .hold_data  (hold_data),
        .commit_en  (commit_en)
    );

    sram_bw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_DW(LANE_DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_addr (hold_addr),
        .wr_mask (hold_mask),
        .wr_data (hold_data),
        .rd_addr (req_addr),
        .rd_data (arr_data)
    );

    // Forwarding: pending write to the read address wins lane by lane
    assign fwd_hit = (hold_state == HOLD_FULL) && (hold_addr == req_addr);

    for (genvar k = 0; k < LANES; k++) begin : g_fwd
        logic take_hold;
        assign take_hold = fwd_hit && hold_mask[k];
        assign fwd_data[k*LANE_DW +: LANE_DW] = take_hold ? hold_data[k*LANE_DW +: LANE_DW]
                                                          : arr_data[k*LANE_DW +: LANE_DW];
        assign fwd_data[PAR_BASE + k] = take_hold ? hold_data[PAR_BASE + k]
                                                  : arr_data[PAR_BASE + k];
    end

    // Flow-through output, gated asynchronously by the output enable
    always_comb begin
        q_drv = (!oe_n) && (req_kind == CYC_READ);
        q     = q_drv ? fwd_data : '0;
    end

    // R1: global write captures a full-lane write
    assert_glob_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !glob_we_n) |=> (req_kind == CYC_WRITE && req_mask == '1));

    // R3: no write control active means a read with nothing masked in
    assert_plain_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && glob_we_n && byte_we_n) |=> (req_kind == CYC_READ && req_mask == '0));

    // R5: a deselected edge leaves the outputs undriven next cycle
    assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> (req_kind == CYC_IDLE && !q_drv));

    // R6: output enable high keeps the drivers off
    assert_oe_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drv);

endmodule

// File: tb/sim_sram_bw_core.sv
`timescale 1ns/1ps
module sim_sram_bw_core;

    localparam int AW  = 6;
    localparam int LN  = 4;
    localparam int LDW = 8;
    localparam int WW  = LN * (LDW + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel;
    logic [AW-1:0] addr;
    logic [WW-1:0] wdata;
    logic [LN-1:0] lane_we_n;
    logic          byte_we_n;
    logic          glob_we_n;
    logic          oe_n;
    logic [WW-1:0] q;
    logic          q_drv;

    int vectors = 0;
    int fails   = 0;

    logic [WW-1:0] model [1 << AW];
    logic          last_wr_valid = 1'b0;
    logic [AW-1:0] last_wr_addr  = '0;

    always #2.5 clk = ~clk;

    sram_bw_core #(.ADDR_W(AW), .LANES(LN), .LANE_DW(LDW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wdata(wdata),
        .lane_we_n(lane_we_n), .byte_we_n(byte_we_n), .glob_we_n(glob_we_n),
        .oe_n(oe_n), .q(q), .q_drv(q_drv)
    );

    // R4: lane k = data bits 8k..8k+7 and parity bit 32+k
    function automatic logic [WW-1:0] lane_bits(input logic [LN-1:0] m);
        logic [WW-1:0] r = '0;
        for (int k = 0; k < LN; k++) begin
            if (m[k]) begin
                r[k*LDW +: LDW] = '1;
                r[LN*LDW + k]   = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [LN-1:0] exp_mask(input logic s, input logic [LN-1:0] lw,
                                               input logic bw, input logic gw);
        if (!s)  return '0;
        if (!gw) return '1;
        if (!bw) return ~lw;
        return '0;
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] exp_q, input logic exp_d);
        vectors++;
        if (q !== exp_q || q_drv !== exp_d) begin
            fails++;
            $display("FAIL %s q=%h q_drv=%b expected q=%h q_drv=%b", tag, q, q_drv, exp_q, exp_d);
        end
    endtask

    task automatic step(input logic s, input logic [AW-1:0] a, input logic [WW-1:0] d,
                        input logic [LN-1:0] lw, input logic bw, input logic gw,
                        input logic oe, input string tag);
        logic [LN-1:0] m;
        logic          rd;
        logic          ed;
        @(negedge clk);
        sel = s; addr = a; wdata = d; lane_we_n = lw;
        byte_we_n = bw; glob_we_n = gw; oe_n = oe;
        @(posedge clk);
        m  = exp_mask(s, lw, bw, gw);
        rd = s && (m == '0);
        if (m != '0) model[a] = (model[a] & ~lane_bits(m)) | (d & lane_bits(m));
        last_wr_valid = (m != '0);
        last_wr_addr  = a;
        #1;
        ed = rd && !oe;
        check(tag, ed ? model[a] : '0, ed);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL R6 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; sel = 1'b0; addr = '0; wdata = '0; lane_we_n = '1;
        byte_we_n = 1'b1; glob_we_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R9 in reset", '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R9 after reset", '0, 1'b0);

        // R1: fill the array with global writes; lane enables held inactive
        for (int i = 0; i < (1 << AW); i++) begin
            step(1'b1, AW'(i), {4'(i), {4{8'(i * 7 + 3)}}}, '1, 1'b1, 1'b0, 1'b0, "R1 fill");
        end
        step(1'b1, 6'd7, 36'hF_1234_5678, 4'b1111, 1'b1, 1'b0, 1'b0, "R1 override");
        step(1'b1, 6'd7, '0, '1, 1'b1, 1'b1, 1'b0, "R1 readback");

        // R4 / R2: single-lane write then readback
        step(1'b1, 6'd5, 36'h5_A5C3_E1F0, 4'b1011, 1'b0, 1'b1, 1'b0, "R4 lane2 write");
        step(1'b1, 6'd20, '0, '1, 1'b1, 1'b1, 1'b0, "R2 unrelated read");
        step(1'b1, 6'd5, '0, '1, 1'b1, 1'b1, 1'b0, "R4 lane2 readback");
        step(1'b1, 6'd5, 36'hA_0F0F_0F0F, 4'b1100, 1'b0, 1'b1, 1'b0, "R2 lanes0-1 write");
        step(1'b1, 6'd5, '0, '1, 1'b1, 1'b1, 1'b0, "R2 two-lane readback");

        // R3: unqualified lane enables and empty lane set both read
        step(1'b1, 6'd6, '1, 4'b0000, 1'b1, 1'b1, 1'b0, "R3 unqualified lanes");
        step(1'b1, 6'd6, '1, 4'b1111, 1'b0, 1'b1, 1'b0, "R3 empty lane set");
        step(1'b1, 6'd6, '0, '1, 1'b1, 1'b1, 1'b0, "R3 contents kept");

        // R5: deselected global write does nothing
        step(1'b0, 6'd8, '1, 4'b0000, 1'b0, 1'b0, 1'b0, "R5 deselected");
        step(1'b1, 6'd8, '0, '1, 1'b1, 1'b1, 1'b0, "R5 contents kept");

        // R7: write followed at once by a read of the same word
        step(1'b1, 6'd9, 36'h9_DEAD_BEEF, 4'b0110, 1'b0, 1'b1, 1'b0, "R7 write lanes0,3");
        step(1'b1, 6'd9, '0, '1, 1'b1, 1'b1, 1'b0, "R7 forward partial");
        step(1'b1, 6'd10, 36'h6_CAFE_F00D, '1, 1'b1, 1'b0, 1'b0, "R7 write full");
        step(1'b1, 6'd10, '0, '1, 1'b1, 1'b1, 1'b0, "R7 forward full");

        // R8: back-to-back writes, then spaced and unrelated reads
        step(1'b1, 6'd11, 36'h1_1111_1111, '1, 1'b1, 1'b0, 1'b0, "R8 write a");
        step(1'b1, 6'd12, 36'h2_2222_2222, '1, 1'b1, 1'b0, 1'b0, "R8 write b");
        step(1'b1, 6'd11, '0, '1, 1'b1, 1'b1, 1'b0, "R8 read a");
        step(1'b1, 6'd13, 36'h3_3333_3333, 4'b0111, 1'b0, 1'b1, 1'b0, "R8 write c");
        step(1'b1, 6'd14, '0, '1, 1'b1, 1'b1, 1'b0, "R8 other address");
        step(1'b1, 6'd12, '0, '1, 1'b1, 1'b1, 1'b0, "R8 read b");

        // R6 / R10: asynchronous output enable between edges
        step(1'b1, 6'd9, '0, '1, 1'b1, 1'b1, 1'b0, "R6 read");
        oe_n = 1'b1;
        #0.5 check("R10 oe released", '0, 1'b0);
        oe_n = 1'b0;
        #0.5 check("R6 oe reasserted", model[9], 1'b1);
        step(1'b1, 6'd9, '0, '1, 1'b1, 1'b1, 1'b1, "R10 read with oe high");

        // Random traffic over a small address window
        for (int n = 0; n < 1500; n++) begin
            logic          s  = ($urandom % 10) != 0;
            logic [AW-1:0] a  = AW'($urandom % 16);
            logic [WW-1:0] d  = {4'($urandom), 32'($urandom)};
            logic [LN-1:0] lw = LN'($urandom);
            logic          gw = ($urandom % 7) != 0;
            logic          bw = ($urandom % 3) != 0;
            logic          oe = ($urandom % 8) == 0;
            logic [LN-1:0] m  = exp_mask(s, lw, bw, gw);
            string         tg;
            if (!s)                                   tg = "R5 random";
            else if (!gw)                             tg = "R1 random";
            else if (m != '0)                         tg = "R2 random";
            else if (last_wr_valid && last_wr_addr == a) tg = "R7 random";
            else                                      tg = "R8 random";
            step(s, a, d, lw, bw, gw, oe, tg);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule